// File: doc/BRIEF.md
# Segment-to-Bus-Word Memory Command Adapter

This block sits between a client that moves memory data in 128-bit segments and a memory controller whose command port counts addresses in 32-bit bus words. The controller's data path is 32 bits wide, so one bus-word address stands for four bytes, and a memory of B bytes has B/4 distinct addresses. Every client transfer becomes exactly one controller command that carries a full 128-bit payload and covers four consecutive bus-word addresses.

The client can choose one of two addressing conventions for each request. In segment mode it gives a segment index n, and the block issues bus-word address 4n, so the client steps its address by one per transfer. In raw mode it gives the bus-word address itself and must step by four (0, 4, 8, ...). A raw address that is not a multiple of four is dropped and flagged. A segment-mode write that fills only part of the segment gets a fixed filler word in its unused lanes, so that every segment is complete and the following segments stay aligned.

Commands leave through a valid/ready handshake and are held unchanged until the controller takes them. Read data comes back in command order. The block limits how many reads can be outstanding.

Top module: `wseg_mem_adapter`

## Requirements
- R1: In segment mode (`usr_raw`=0) a request with address n produces one command with `mc_cmd_addr` = 4n (n shifted left by two) and `mc_cmd_write` equal to `usr_write`.
- R2: In raw mode (`usr_raw`=1) a request whose address has its two low bits at zero produces one command with `mc_cmd_addr` equal to `usr_addr`.
- R3: A raw-mode request whose address has a non-zero value in its two low bits is accepted, issues no command, and raises `usr_err` for exactly the one cycle after acceptance. Every other accepted request leaves `usr_err` low.
- R4: In a segment-mode write, lane k of the payload is bits [32k+31:32k]. `usr_wlen` gives the number of valid lanes minus one. Lanes 0..`usr_wlen` carry the client data and lanes above it carry `PAD_WORD` (default 32'hDEAD_BEEF).
- R5: In a raw-mode write the payload equals `usr_wdata` bit for bit, and `usr_wlen` has no effect.
- R6: While `mc_cmd_valid` is high and `mc_cmd_ready` is low, the command's valid, write flag, address and data stay unchanged in the next cycle.
- R7: Each `mc_rd_valid` pulse produces a `usr_rd_valid` pulse one cycle later carrying the same data, so reads return in issue order.
- R8: Once `MAX_RD` (default 4) accepted reads have no returned data yet, `usr_ready` is low until a read returns.
- R9: When reset is active, `mc_cmd_valid`, `usr_err` and `usr_rd_valid` are low. After reset, `usr_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| usr_valid | input | 1 | Client request present |
| usr_ready | output | 1 | Client request taken this cycle when valid |
| usr_write | input | 1 | 1 = write, 0 = read |
| usr_raw | input | 1 | 1 = raw bus-word address, 0 = segment index |
| usr_addr | input | BADDR_W (24) | Request address |
| usr_wlen | input | 2 | Valid lanes minus one (segment-mode writes) |
| usr_wdata | input | DATA_W (128) | Write payload |
| usr_err | output | 1 | Misaligned raw request dropped |
| usr_rd_valid | output | 1 | Read data strobe to client |
| usr_rd_data | output | DATA_W (128) | Read data to client |
| mc_cmd_valid | output | 1 | Command present to controller |
| mc_cmd_ready | input | 1 | Controller takes command |
| mc_cmd_write | output | 1 | Command is a write |
| mc_cmd_addr | output | BADDR_W (24) | Bus-word address of command |
| mc_cmd_wdata | output | DATA_W (128) | Command write payload |
| mc_rd_valid | input | 1 | Read data strobe from controller |
| mc_rd_data | input | DATA_W (128) | Read data from controller |

## Verification
A command becomes visible on the controller port in the cycle after the client handshake. After that it can only leave on a later controller handshake. The bench therefore compares commands only on the falling edge that comes before a handshake edge, with valid and ready both seen high. `usr_err` is due exactly one cycle after a misaligned acceptance and is checked at the falling edge that follows. Read data is due one cycle after the controller strobe. The monitor checks returned data against its queue at each falling edge, before it drives the next strobe, so every return is matched with the read that caused it.

// File: rtl/wma_pkg.sv
package wma_pkg;
   typedef enum logic {
      MODE_SEG = 1'b0,
      MODE_RAW = 1'b1
   } addr_mode_e;

   typedef struct packed {
      logic fwd;
      logic err;
   } req_fate_t;
endpackage

// File: rtl/wma_addr_xlate.sv
module wma_addr_xlate #(
   parameter int BADDR_W = 24,
   parameter int LANE_SH = 2,
   parameter bit RAW_EN  = 1'b1
) (
   input  logic               mode_raw,
   input  logic [BADDR_W-1:0] addr_in,
   output logic [BADDR_W-1:0] bus_addr,
   output logic               raw_sel,
   output logic               misaligned
);
   import wma_pkg::*;
   localparam int SEG_W = BADDR_W - LANE_SH;

   logic [BADDR_W-1:0] seg_addr;
   assign seg_addr = {addr_in[SEG_W-1:0], {LANE_SH{1'b0}}};

   generate
      if (RAW_EN) begin : g_dual
         addr_mode_e mode;
         assign mode       = addr_mode_e'(mode_raw);
         assign raw_sel    = (mode == MODE_RAW);
         assign misaligned = raw_sel && (|addr_in[LANE_SH-1:0]);
         assign bus_addr   = raw_sel ? addr_in : seg_addr;
      end else begin : g_seg_only
         logic unused_mode;
         logic [LANE_SH-1:0] unused_hi;
         assign unused_mode = mode_raw;
         assign unused_hi   = addr_in[BADDR_W-1 -: LANE_SH];
         assign raw_sel     = 1'b0;
         assign misaligned  = 1'b0;
         assign bus_addr    = seg_addr;
      end
   endgenerate
endmodule

// File: rtl/wma_lane_pad.sv
module wma_lane_pad #(
   parameter int                DATA_W   = 128,
   parameter int                BUS_W    = 32,
   parameter int                LANE_SH  = 2,
   parameter logic [BUS_W-1:0]  PAD_WORD = 32'hDEAD_BEEF
) (
   input  logic               pad_en,
   input  logic [LANE_SH-1:0] last_lane,
   input  logic [DATA_W-1:0]  din,
   output logic [DATA_W-1:0]  dout
);
   localparam int LANES = DATA_W / BUS_W;

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         localparam logic [LANE_SH:0] IDX = (LANE_SH+1)'(i);
         logic beyond;
         assign beyond = pad_en && (IDX > {1'b0, last_lane});
         assign dout[i*BUS_W +: BUS_W] = beyond ? PAD_WORD : din[i*BUS_W +: BUS_W];
      end
   endgenerate
endmodule

// File: rtl/wma_cmd_slot.sv
module wma_cmd_slot #(
   parameter int PAY_W = 153
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PAY_W-1:0] pay_in,
   input  logic             take,
   output logic             full,
   output logic [PAY_W-1:0] pay_out
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full    <= 1'b0;
         pay_out <= '0;
      end else if (load) begin
         full    <= 1'b1;
         pay_out <= pay_in;
      end else if (take) begin
         full    <= 1'b0;
      end
   end
endmodule

// File: rtl/wma_rd_track.sv
module wma_rd_track #(
   parameter int DATA_W = 128,
   parameter int MAX_RD = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_issue,
   input  logic              rd_back,
   input  logic [DATA_W-1:0] rd_data_in,
   output logic              credit_ok,
   output logic              rd_valid_out,
   output logic [DATA_W-1:0] rd_data_out
);
   localparam int CNT_W = $clog2(MAX_RD + 1);
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_RD);

   logic [CNT_W-1:0] pend_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_cnt <= '0;
      end else begin
         case ({rd_issue, rd_back})
            2'b10:   pend_cnt <= pend_cnt + 1'b1;
            2'b01:   pend_cnt <= pend_cnt - 1'b1;
            default: pend_cnt <= pend_cnt;
         endcase
      end
   end

   assign credit_ok = (pend_cnt < LIMIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid_out <= 1'b0;
         rd_data_out  <= '0;
      end else begin
         rd_valid_out <= rd_back;
         if (rd_back) rd_data_out <= rd_data_in;
      end
   end
endmodule

// File: rtl/wseg_mem_adapter.sv
module wseg_mem_adapter #(
   parameter int               DATA_W   = 128,
   parameter int               BUS_W    = 32,
   parameter int               BADDR_W  = 24,
   parameter int               MAX_RD   = 4,
   parameter bit               RAW_EN   = 1'b1,
   parameter logic [BUS_W-1:0] PAD_WORD = 32'hDEAD_BEEF,
   localparam int              LANES    = DATA_W / BUS_W,
   localparam int              LANE_SH  = $clog2(LANES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               usr_valid,
   output logic               usr_ready,
   input  logic               usr_write,
   input  logic               usr_raw,
   input  logic [BADDR_W-1:0] usr_addr,
   input  logic [LANE_SH-1:0] usr_wlen,
   input  logic [DATA_W-1:0]  usr_wdata,
   output logic               usr_err,
   output logic               usr_rd_valid,
   output logic [DATA_W-1:0]  usr_rd_data,
   output logic               mc_cmd_valid,
   input  logic               mc_cmd_ready,
   output logic               mc_cmd_write,
   output logic [BADDR_W-1:0] mc_cmd_addr,
   output logic [DATA_W-1:0]  mc_cmd_wdata,
   input  logic               mc_rd_valid,
   input  logic [DATA_W-1:0]  mc_rd_data
);
   import wma_pkg::*;

   localparam int PAY_W = 1 + BADDR_W + DATA_W;

   generate
      if (DATA_W % BUS_W != 0) begin : g_bad_ratio
         $error("DATA_W must be a whole multiple of BUS_W");
      end
      if (LANES < 2 || (1 << LANE_SH) != LANES) begin : g_bad_lanes
         $error("lane count must be a power of two of at least 2");
      end
      if (BADDR_W <= LANE_SH) begin : g_bad_addr
         $error("BADDR_W too narrow for lane shift");
      end
      if (MAX_RD < 1) begin : g_bad_rd
         $error("MAX_RD must be at least 1");
      end
   endgenerate

   logic [BADDR_W-1:0] xl_addr;
   logic               xl_raw;
   logic               xl_mis;

   wma_addr_xlate #(
      .BADDR_W (BADDR_W),
      .LANE_SH (LANE_SH),
      .RAW_EN  (RAW_EN)
   ) u_xlate (
      .mode_raw   (usr_raw),
      .addr_in    (usr_addr),
      .bus_addr   (xl_addr),
      .raw_sel    (xl_raw),
      .misaligned (xl_mis)
   );

   logic [DATA_W-1:0] padded;

   wma_lane_pad #(
      .DATA_W   (DATA_W),
      .BUS_W    (BUS_W),
      .LANE_SH  (LANE_SH),
      .PAD_WORD (PAD_WORD)
   ) u_pad (
      .pad_en    (usr_write && !xl_raw),
      .last_lane (usr_wlen),
      .din       (usr_wdata),
      .dout      (padded)
   );

   logic      accept;
   req_fate_t fate;
   logic      slot_full;
   logic      credit_ok;
   logic [PAY_W-1:0] slot_out;

   assign usr_ready = (!slot_full || mc_cmd_ready) && credit_ok;
   assign accept    = usr_valid && usr_ready;
   assign fate.fwd  = accept && !xl_mis;
   assign fate.err  = accept && xl_mis;

   wma_cmd_slot #(
      .PAY_W (PAY_W)
   ) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (fate.fwd),
      .pay_in  ({usr_write, xl_addr, padded}),
      .take    (mc_cmd_ready),
      .full    (slot_full),
      .pay_out (slot_out)
   );

   assign mc_cmd_valid = slot_full;
   assign {mc_cmd_write, mc_cmd_addr, mc_cmd_wdata} = slot_out;

   wma_rd_track #(
      .DATA_W (DATA_W),
      .MAX_RD (MAX_RD)
   ) u_rd (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_issue     (fate.fwd && !usr_write),
      .rd_back      (mc_rd_valid),
      .rd_data_in   (mc_rd_data),
      .credit_ok    (credit_ok),
      .rd_valid_out (usr_rd_valid),
      .rd_data_out  (usr_rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) usr_err <= 1'b0;
      else        usr_err <= fate.err;
   end
endmodule

// File: rtl/wma_checker.sv
module wma_checker #(
   parameter int BADDR_W = 24,
   parameter int DATA_W  = 128,
   parameter int LANE_SH = 2,
   parameter int MAX_RD  = 4,
   parameter bit RAW_EN  = 1'b1
) (
   input logic               clk,
   input logic               rst_n,
   input logic               usr_valid,
   input logic               usr_ready,
   input logic               usr_write,
   input logic               usr_raw,
   input logic [BADDR_W-1:0] usr_addr,
   input logic               usr_err,
   input logic               usr_rd_valid,
   input logic [DATA_W-1:0]  usr_rd_data,
   input logic               mc_cmd_valid,
   input logic               mc_cmd_ready,
   input logic               mc_cmd_write,
   input logic [BADDR_W-1:0] mc_cmd_addr,
   input logic [DATA_W-1:0]  mc_cmd_wdata,
   input logic               mc_rd_valid,
   input logic [DATA_W-1:0]  mc_rd_data
);
   localparam int SEG_W = BADDR_W - LANE_SH;

   logic take;
   logic bad_raw;
   assign take    = usr_valid && usr_ready;
   assign bad_raw = RAW_EN && usr_raw && (|usr_addr[LANE_SH-1:0]);

   logic [7:0] open_rd;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) open_rd <= '0;
      else open_rd <= open_rd + 8'(take && !usr_write && !bad_raw) - 8'(mc_rd_valid);
   end

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mc_cmd_valid && !mc_cmd_ready |=> mc_cmd_valid && $stable(mc_cmd_addr)
         && $stable(mc_cmd_wdata) && $stable(mc_cmd_write));

   assert_seg_map_R1: assert property (@(posedge clk) disable iff (!rst_n)
      take && !usr_raw |=> mc_cmd_valid
         && mc_cmd_addr == {$past(usr_addr[SEG_W-1:0]), {LANE_SH{1'b0}}});

   assert_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mc_cmd_valid |-> mc_cmd_addr[LANE_SH-1:0] == '0);

   assert_misalign_R3: assert property (@(posedge clk) disable iff (!rst_n)
      take && bad_raw |=> usr_err);

   assert_err_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      usr_err |-> $past(take) && $past(bad_raw));

   assert_rd_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mc_rd_valid |=> usr_rd_valid && usr_rd_data == $past(mc_rd_data));

   assert_rd_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      open_rd >= 8'(MAX_RD) |-> !usr_ready);
endmodule

bind wseg_mem_adapter wma_checker #(
   .BADDR_W (BADDR_W),
   .DATA_W  (DATA_W),
   .LANE_SH (LANE_SH),
   .MAX_RD  (MAX_RD),
   .RAW_EN  (RAW_EN)
) u_wma_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .usr_valid    (usr_valid),
   .usr_ready    (usr_ready),
   .usr_write    (usr_write),
   .usr_raw      (usr_raw),
   .usr_addr     (usr_addr),
   .usr_err      (usr_err),
   .usr_rd_valid (usr_rd_valid),
   .usr_rd_data  (usr_rd_data),
   .mc_cmd_valid (mc_cmd_valid),
   .mc_cmd_ready (mc_cmd_ready),
   .mc_cmd_write (mc_cmd_write),
   .mc_cmd_addr  (mc_cmd_addr),
   .mc_cmd_wdata (mc_cmd_wdata),
   .mc_rd_valid  (mc_rd_valid),
   .mc_rd_data   (mc_rd_data)
);

// File: tb/test_wseg_mem_adapter.sv
module test_wseg_mem_adapter;
   localparam int AW = 24;
   localparam int DW = 128;
   localparam logic [31:0] PAD = 32'hDEAD_BEEF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          usr_valid = 1'b0, usr_write = 1'b0, usr_raw = 1'b0;
   logic [AW-1:0] usr_addr = '0;
   logic [1:0]    usr_wlen = '0;
   logic [DW-1:0] usr_wdata = '0;
   logic          usr_ready, usr_err, usr_rd_valid;
   logic [DW-1:0] usr_rd_data;
   logic          mc_cmd_valid, mc_cmd_write;
   logic          mc_cmd_ready = 1'b0;
   logic [AW-1:0] mc_cmd_addr;
   logic [DW-1:0] mc_cmd_wdata;
   logic          mc_rd_valid = 1'b0;
   logic [DW-1:0] mc_rd_data = '0;

   always #10 clk = ~clk;

   wseg_mem_adapter i_wseg_mem_adapter (
      .clk(clk), .rst_n(rst_n),
      .usr_valid(usr_valid), .usr_ready(usr_ready), .usr_write(usr_write),
      .usr_raw(usr_raw), .usr_addr(usr_addr), .usr_wlen(usr_wlen),
      .usr_wdata(usr_wdata), .usr_err(usr_err), .usr_rd_valid(usr_rd_valid),
      .usr_rd_data(usr_rd_data), .mc_cmd_valid(mc_cmd_valid),
      .mc_cmd_ready(mc_cmd_ready), .mc_cmd_write(mc_cmd_write),
      .mc_cmd_addr(mc_cmd_addr), .mc_cmd_wdata(mc_cmd_wdata),
      .mc_rd_valid(mc_rd_valid), .mc_rd_data(mc_rd_data)
   );

   typedef struct {
      logic          wr;
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      string         tag;
   } exp_cmd_t;

   exp_cmd_t      cmd_q[$];
   logic [DW-1:0] pend_q[$];
   logic [DW-1:0] ret_q[$];
   int  n_chk = 0, n_bad = 0, cyc = 0, rdy_mode = 0;
   bit  rd_en = 1'b1, mon_on = 1'b0, stall_prev = 1'b0;
   logic          s_wr;
   logic [AW-1:0] s_a;
   logic [DW-1:0] s_d;

   task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] rd_pattern(input logic [AW-1:0] a);
      return {8'h40, a, 8'h30, a, 8'h20, a, 8'h10, a};
   endfunction

   // controller model and scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      if (mon_on) begin
         if (usr_rd_valid) begin
            if (ret_q.size() == 0) chk(0, "R7 unexpected read data", usr_rd_data, '0);
            else begin
               logic [DW-1:0] e;
               e = ret_q.pop_front();
               chk(usr_rd_data == e, "R7 read data/order", usr_rd_data, e);
            end
         end
         if (rd_en && pend_q.size() > 0 && cyc[0]) begin
            mc_rd_valid = 1'b1;
            mc_rd_data  = pend_q.pop_front();
            ret_q.push_back(mc_rd_data);
         end else begin
            mc_rd_valid = 1'b0;
         end
         if (stall_prev)
            chk(mc_cmd_valid && mc_cmd_wr_eq() && mc_cmd_addr == s_a && mc_cmd_wdata == s_d,
                "R6 held command", {mc_cmd_valid, mc_cmd_addr}, {1'b1, s_a});
         case (rdy_mode)
            0: mc_cmd_ready = 1'b1;
            1: mc_cmd_ready = (cyc % 3) != 0;
            default: mc_cmd_ready = 1'b0;
         endcase
         #1;
         if (mc_cmd_valid && mc_cmd_ready) begin
            if (cmd_q.size() == 0) chk(0, "R3 unexpected command", {mc_cmd_write, mc_cmd_addr}, '0);
            else begin
               exp_cmd_t e;
               e = cmd_q.pop_front();
               chk(mc_cmd_write == e.wr && mc_cmd_addr == e.a, {e.tag, " addr"},
                   {mc_cmd_write, mc_cmd_addr}, {e.wr, e.a});
               if (e.wr) chk(mc_cmd_wdata == e.d, {e.tag, " data"}, mc_cmd_wdata, e.d);
               else pend_q.push_back(rd_pattern(mc_cmd_addr));
            end
         end
         stall_prev = mc_cmd_valid && !mc_cmd_ready;
         s_wr = mc_cmd_write; s_a = mc_cmd_addr; s_d = mc_cmd_wdata;
      end
   end

   function automatic bit mc_cmd_wr_eq();
      return mc_cmd_write == s_wr;
   endfunction

   task automatic req(input bit wr, input bit raw, input logic [AW-1:0] a,
                      input logic [1:0] wlen, input logic [DW-1:0] d,
                      input bit exp_err, input string tag);
      exp_cmd_t e;
      @(negedge clk);
      usr_valid = 1'b1; usr_write = wr; usr_raw = raw;
      usr_addr = a; usr_wlen = wlen; usr_wdata = d;
      #2;
      while (!usr_ready) begin @(negedge clk); #2; end
      if (!exp_err) begin
         e.wr = wr; e.tag = tag;
         e.a  = raw ? a : {a[AW-3:0], 2'b00};
         e.d  = d;
         if (wr && !raw)
            for (int k = 0; k < 4; k++)
               if (k > int'(wlen)) e.d[k*32 +: 32] = PAD;
         cmd_q.push_back(e);
      end
      @(posedge clk); #1;
      usr_valid = 1'b0;
      @(negedge clk);
      chk(usr_err == exp_err, "R3 error flag", DW'(usr_err), DW'(exp_err));
   endtask

   task automatic drain();
      int guard = 0;
      while ((cmd_q.size() || pend_q.size() || ret_q.size() || mc_cmd_valid) && guard < 500) begin
         @(negedge clk); guard++;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!mc_cmd_valid && !usr_err && !usr_rd_valid, "R9 outputs in reset",
          {mc_cmd_valid, usr_err, usr_rd_valid}, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(usr_ready == 1'b1, "R9 ready after reset", DW'(usr_ready), 1);
      mon_on = 1'b1;

      // segment-mode full writes
      req(1, 0, 24'h000000, 2'd3, {32'hA3, 32'hA2, 32'hA1, 32'hA0}, 0, "R1 seg write");
      req(1, 0, 24'h000001, 2'd3, {4{32'h1234_5678}}, 0, "R1 seg write");
      req(1, 0, 24'h3FFFFF, 2'd3, {4{32'hCAFE_F00D}}, 0, "R1 seg top index");
      // partial segments padded
      req(1, 0, 24'h000005, 2'd0, {32'h3, 32'h2, 32'h1, 32'h0}, 0, "R4 pad one lane");
      req(1, 0, 24'h000006, 2'd1, {32'h13, 32'h12, 32'h11, 32'h10}, 0, "R4 pad two lanes");
      req(1, 0, 24'h000007, 2'd2, {32'h23, 32'h22, 32'h21, 32'h20}, 0, "R4 pad three lanes");
      // raw aligned writes, wlen ignored
      req(1, 1, 24'h000000, 2'd0, {32'hB3, 32'hB2, 32'hB1, 32'hB0}, 0, "R5 raw write");
      req(1, 1, 24'h000004, 2'd1, {4{32'h5555_AAAA}}, 0, "R2 raw write");
      req(1, 1, 24'h000100, 2'd0, {32'hC3, 32'hC2, 32'hC1, 32'hC0}, 0, "R5 raw write");
      // misaligned raw requests dropped
      req(1, 1, 24'h000001, 2'd3, '1, 1, "R3");
      req(0, 1, 24'h000002, 2'd3, '0, 1, "R3");
      req(1, 1, 24'h000003, 2'd3, '1, 1, "R3");
      drain();

      // controller stall
      rdy_mode = 2;
      req(1, 0, 24'h000010, 2'd3, {4{32'h0F0F_0F0F}}, 0, "R6 stalled write");
      repeat (5) @(negedge clk);
      rdy_mode = 0;
      drain();

      // reads under irregular ready
      rdy_mode = 1;
      req(0, 0, 24'h000002, 2'd0, '0, 0, "R1 seg read");
      req(0, 1, 24'h000008, 2'd0, '0, 0, "R2 raw read");
      req(0, 0, 24'h000009, 2'd0, '0, 0, "R7 seg read");
      req(1, 0, 24'h000003, 2'd3, {4{32'h7777_0000}}, 0, "R1 write amid reads");
      req(0, 1, 24'h00000C, 2'd0, '0, 0, "R7 raw read");
      drain();

      // outstanding read limit
      rdy_mode = 0; rd_en = 1'b0;
      for (int k = 0; k < 4; k++) req(0, 0, AW'(k + 32), 2'd0, '0, 0, "R8 read");
      @(negedge clk);
      usr_valid = 1'b1; usr_write = 1'b0; usr_raw = 1'b0; usr_addr = 24'h000050;
      #2;
      for (int k = 0; k < 3; k++) begin
         chk(usr_ready == 1'b0, "R8 ready held low", DW'(usr_ready), 0);
         @(negedge clk); #2;
      end
      usr_valid = 1'b0;
      rd_en = 1'b1;
      drain();
      @(negedge clk); #2;
      chk(usr_ready == 1'b1, "R8 ready after returns", DW'(usr_ready), 1);

      chk(cmd_q.size() == 0 && ret_q.size() == 0, "R7 all results seen",
          DW'(cmd_q.size() + ret_q.size()), 0);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule